// File: doc/BRIEF.md
# Conditional Stream Compaction and Split Unit

This unit takes a stream of data words, each paired with a one-bit case value, and produces densely packed output streams with no idle slots. In compact mode it keeps only the words whose case bit is 1 and packs them onto output lane 0. Words with case bit 0 are consumed and leave no trace. In split mode it sorts every word by its case bit into one of two homogeneous lanes: case 0 goes to lane 0 and case 1 goes to lane 1. Each lane keeps the input order of the words it receives.

Input arrives one word per cycle through a valid/ready handshake. Each lane has its own valid/ready handshake. A word with the input last flag set closes the stream. Each active lane then marks its final word with a last flag. An active lane that received nothing emits a single empty end marker instead. Lane 0 is the only active lane in compact mode, and both lanes are active in split mode.

A lane holds one word in reserve, so it can tell whether that word is its last. A word therefore leaves its lane only when the next word for that lane arrives, or when the stream ends. After the end markers have been loaded, the unit shows the per-lane element counts for one cycle and then accepts the next stream.

The control state machine has three states:
- ST_RUN accepts words. It moves to ST_FLUSH when a word carrying the last flag is accepted.
- ST_FLUSH loads each active lane's end beat when that lane's output register is free. It moves to ST_REPORT once every active lane has loaded its end beat.
- ST_REPORT presents the counts and clears the counters. It always returns to ST_RUN on the next cycle.

`mode_split` must be held steady from the first word of a stream until its count report.

Top module: `cond_stream_sorter`

## Requirements
- R1: After reset, `out_valid` is 0 on both lanes, `counts_valid` is 0, and `in_ready` is 1.
- R2: With `mode_split`=0, words with `in_case`=1 appear on lane 0 in input order. Words with `in_case`=0 produce no output beat. Lane 1 never asserts `out_valid`.
- R3: With `mode_split`=1, words with `in_case`=0 appear on lane 0 and words with `in_case`=1 appear on lane 1, each lane in input order, with no word lost or duplicated.
- R4: When a word with `in_last`=1 is accepted, the final beat of every active lane carries `out_last`=1, and no earlier beat of that stream does.
- R5: An active lane that received no word in a stream emits exactly one beat with `out_last`=1, `out_empty`=1 and data 0. A beat with `out_empty`=1 always has `out_last`=1.
- R6: While a lane shows `out_valid`=1 with `out_ready`=0, its valid, data, last and empty outputs stay unchanged into the next cycle.
- R7: A stalled lane never loses a word. `in_ready` falls only when the destination lane cannot take the word. A word dropped in compact mode (`in_case`=0) is accepted even while lane 0 is stalled.
- R8: After the end beats of a stream are loaded, `counts_valid` is 1 for exactly one cycle. At that point `count0` and `count1` equal the number of words routed to lane 0 and lane 1 in that stream, with empty markers not counted.
- R9: In the cycle after a word with `in_last`=1 is accepted, and during the `counts_valid` cycle, `in_ready` is 0. The next stream is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_split | input | 1 | 0 = compact onto lane 0, 1 = split by case bit |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Input word |
| in_case | input | 1 | Case bit selecting keep/drop or lane |
| in_last | input | 1 | Final word of the input stream |
| out_valid | output | 2 | Per-lane output valid (bit i = lane i) |
| out_ready | input | 2 | Per-lane downstream ready |
| out_last | output | 2 | Per-lane final beat of the stream |
| out_empty | output | 2 | Per-lane empty end marker (no data) |
| out_data0 | output | DATA_W | Lane 0 output word |
| out_data1 | output | DATA_W | Lane 1 output word |
| counts_valid | output | 1 | One-cycle pulse presenting the counts |
| count0 | output | CNT_W | Words routed to lane 0 in the finished stream |
| count1 | output | CNT_W | Words routed to lane 1 in the finished stream |

## Verification
Two things can happen in the same cycle. A lane can push its reserved word into its output register while downstream is taking the previous word out of that same register. The stream end can also arrive while one lane is stalled and the other is free, so the two lanes load their end beats in different cycles. The bench provokes both by driving each lane's ready randomly and at different rates, including one lane held mostly low, and sends streams that end with a word for either lane. A behavioural model keeps an expected-beat queue per lane. It compares every transferred beat, checks that stalled outputs stay put, and checks the count report against what was routed. Any lost, repeated, reordered or wrongly flagged beat is reported.

// File: rtl/css_pkg.sv
`timescale 1ns/1ps
package css_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_REPORT = 2'd2
    } css_state_e;

    // lanes that take part in a stream for a given mode
    function automatic logic [NUM_LANES-1:0] active_lanes(input logic split);
        logic [NUM_LANES-1:0] act;
        act = '0;
        act[0] = 1'b1;
        if (split) act = '1;
        return act;
    endfunction
endpackage

// File: rtl/css_router.sv
`timescale 1ns/1ps
module css_router #(
    parameter int LANES = 2
) (
    input  logic             split_mode,
    input  logic             case_bit,
    output logic [LANES-1:0] lane_sel
);
    // one-hot destination; all zero means the word is dropped
    always_comb begin
        lane_sel = '0;
        if (split_mode) begin
            lane_sel[case_bit] = 1'b1;
        end else if (case_bit) begin
            lane_sel[0] = 1'b1;
        end
    end
endmodule

// File: rtl/css_lane.sv
`timescale 1ns/1ps
module css_lane #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush_req,
    input  logic              clear,
    input  logic              out_ready,
    output logic              can_take,
    output logic              flushed,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_empty,
    output logic [CNT_W-1:0]  count
);
    logic              hold_vld;
    logic [DATA_W-1:0] hold_dat;
    logic              out_free;

    assign out_free = !out_valid || out_ready;
    assign can_take = !hold_vld || out_free;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_dat  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_empty <= 1'b0;
            flushed   <= 1'b0;
            count     <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (push) begin
                // reserved word is now known not to be last
                if (hold_vld) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_dat;
                    out_last  <= 1'b0;
                    out_empty <= 1'b0;
                end
                hold_vld <= 1'b1;
                hold_dat <= push_data;
                count    <= count + 1'b1;
            end else if (flush_req && !flushed && out_free) begin
                out_valid <= 1'b1;
                out_data  <= hold_vld ? hold_dat : '0;
                out_last  <= 1'b1;
                out_empty <= !hold_vld;
                hold_vld  <= 1'b0;
                flushed   <= 1'b1;
            end
            if (clear) begin
                flushed <= 1'b0;
                count   <= '0;
            end
        end
    end
endmodule

// File: rtl/cond_stream_sorter.sv
`timescale 1ns/1ps
module cond_stream_sorter #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_case,
    input  logic              in_last,
    output logic [1:0]        out_valid,
    input  logic [1:0]        out_ready,
    output logic [1:0]        out_last,
    output logic [1:0]        out_empty,
    output logic [DATA_W-1:0] out_data0,
    output logic [DATA_W-1:0] out_data1,
    output logic              counts_valid,
    output logic [CNT_W-1:0]  count0,
    output logic [CNT_W-1:0]  count1
);
    import css_pkg::*;

    localparam int LANES = NUM_LANES;

    css_state_e        state_q, state_d;
    logic [LANES-1:0]  sel;
    logic [LANES-1:0]  act;
    logic [LANES-1:0]  take_ok;
    logic [LANES-1:0]  lane_flushed;
    logic [LANES-1:0]  push;
    logic [LANES-1:0]  flush_req;
    logic              clear;
    logic              all_flushed;
    logic              accept_last;
    logic [DATA_W-1:0] lane_data [LANES];
    logic [CNT_W-1:0]  lane_cnt  [LANES];

    css_router #(.LANES(LANES)) i_router (
        .split_mode (mode_split),
        .case_bit   (in_case),
        .lane_sel   (sel)
    );

    assign act         = active_lanes(mode_split);
    assign all_flushed = &(lane_flushed | ~act);
    assign accept_last = in_valid && in_ready && in_last;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign push[g] = in_valid && in_ready && sel[g];
            css_lane #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push[g]),
                .push_data (in_data),
                .flush_req (flush_req[g]),
                .clear     (clear),
                .out_ready (out_ready[g]),
                .can_take  (take_ok[g]),
                .flushed   (lane_flushed[g]),
                .out_valid (out_valid[g]),
                .out_data  (lane_data[g]),
                .out_last  (out_last[g]),
                .out_empty (out_empty[g]),
                .count     (lane_cnt[g])
            );
        end
    endgenerate

    assign out_data0 = lane_data[0];
    assign out_data1 = lane_data[1];
    assign count0    = lane_cnt[0];
    assign count1    = lane_cnt[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (accept_last) state_d = ST_FLUSH;
            ST_FLUSH:  if (all_flushed) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs per state
    always_comb begin
        in_ready     = 1'b0;
        flush_req    = '0;
        clear        = 1'b0;
        counts_valid = 1'b0;
        unique case (state_q)
            ST_RUN:    in_ready = ((sel & take_ok) == sel);
            ST_FLUSH:  flush_req = act;
            ST_REPORT: begin
                clear        = 1'b1;
                counts_valid = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/css_checker.sv
`timescale 1ns/1ps
module css_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic [1:0]        out_valid,
    input logic [1:0]        out_ready,
    input logic [1:0]        out_last,
    input logic [1:0]        out_empty,
    input logic [DATA_W-1:0] out_data0,
    input logic [DATA_W-1:0] out_data1,
    input logic              counts_valid
);
    AST_EMPTY_IS_LAST0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] && out_empty[0] |-> out_last[0]); // R5
    AST_EMPTY_IS_LAST1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] && out_empty[1] |-> out_last[1]); // R5
    AST_HOLD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] && !out_ready[0] |=> out_valid[0] && $stable(out_data0)
            && $stable(out_last[0]) && $stable(out_empty[0])); // R6
    AST_HOLD_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] && !out_ready[1] |=> out_valid[1] && $stable(out_data1)
            && $stable(out_last[1]) && $stable(out_empty[1])); // R6
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready); // R9
    AST_REPORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        counts_valid |-> !in_ready); // R9
    AST_COUNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        counts_valid |=> !counts_valid); // R8
endmodule

bind cond_stream_sorter css_checker #(.DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_last      (in_last),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_last     (out_last),
    .out_empty    (out_empty),
    .out_data0    (out_data0),
    .out_data1    (out_data1),
    .counts_valid (counts_valid)
);

// File: tb/test_cond_stream_sorter.sv
`timescale 1ns/1ps
module test_cond_stream_sorter;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_split = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_case = 1'b0;
    logic          in_last = 1'b0;
    logic [1:0]    out_valid;
    logic [1:0]    out_ready = 2'b00;
    logic [1:0]    out_last;
    logic [1:0]    out_empty;
    logic [DW-1:0] out_data0;
    logic [DW-1:0] out_data1;
    logic          counts_valid;
    logic [CW-1:0] count0;
    logic [CW-1:0] count1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    logic [DW+1:0] expq0 [$];
    logic [DW+1:0] expq1 [$];
    logic [DW-1:0] pend_d [2];
    bit            pend_v [2];
    int            rcnt [2];
    int            expc0 [$];
    int            expc1 [$];
    bit            await_counts = 0;
    bit            last_prev = 0;
    bit            stall_prev [2];
    logic [DW+1:0] beat_prev [2];
    int            rdy_pct [2];
    logic [DW-1:0] seq = 16'h1000;

    always #2 clk = ~clk;

    cond_stream_sorter #(.DATA_W(DW), .CNT_W(CW)) i_cond_stream_sorter (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_case(in_case), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_empty(out_empty), .out_data0(out_data0), .out_data1(out_data1),
        .counts_valid(counts_valid), .count0(count0), .count1(count1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // downstream ready generator
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < 2; i++)
            out_ready[i] <= ($urandom_range(0, 99) < rdy_pct[i]);
    end

    // monitor and reference model, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                logic [DW+1:0] cur;
                cur = (i == 0) ? {out_data0, out_last[0], out_empty[0]}
                               : {out_data1, out_last[1], out_empty[1]};
                if (stall_prev[i]) begin
                    check(out_valid[i] && cur == beat_prev[i], "R6", "stalled beat changed",
                          {out_valid[i], cur}, {1'b1, beat_prev[i]});
                end
                if (out_valid[i] && out_ready[i]) begin
                    if (i == 0) begin
                        if (expq0.size() == 0) check(0, "R2", "unexpected lane0 beat", cur, 0);
                        else begin
                            logic [DW+1:0] e;
                            e = expq0.pop_front();
                            check(cur == e, e[0] ? "R5" : (e[1] ? "R4" : "R3"), "lane0 beat", cur, e);
                        end
                    end else begin
                        if (expq1.size() == 0) check(0, "R2", "unexpected lane1 beat", cur, 0);
                        else begin
                            logic [DW+1:0] e;
                            e = expq1.pop_front();
                            check(cur == e, e[0] ? "R5" : (e[1] ? "R4" : "R3"), "lane1 beat", cur, e);
                        end
                    end
                end
                stall_prev[i] = out_valid[i] && !out_ready[i];
                beat_prev[i]  = cur;
            end
            if (last_prev)
                check(!in_ready, "R9", "in_ready after last", in_ready, 0);
            if (!await_counts && in_valid && !mode_split && !in_case)
                check(in_ready, "R7", "dropped word stalled", in_ready, 1);
            if (counts_valid) begin
                check(await_counts, "R8", "unexpected count pulse", 1, 0);
                check(!in_ready, "R9", "in_ready during report", in_ready, 0);
                if (expc0.size() > 0) begin
                    int e0, e1;
                    e0 = expc0.pop_front();
                    e1 = expc1.pop_front();
                    check(count0 == CW'(e0), "R8", "count0", count0, e0);
                    check(count1 == CW'(e1), "R8", "count1", count1, e1);
                end
                await_counts = 0;
            end
            last_prev = 0;
            if (in_valid && in_ready) begin
                int  ln;
                bit  keep;
                ln   = mode_split ? int'(in_case) : 0;
                keep = mode_split || in_case;
                if (keep) begin
                    if (pend_v[ln]) begin
                        if (ln == 0) expq0.push_back({pend_d[ln], 2'b00});
                        else         expq1.push_back({pend_d[ln], 2'b00});
                    end
                    pend_v[ln] = 1;
                    pend_d[ln] = in_data;
                    rcnt[ln]++;
                end
                if (in_last) begin
                    for (int k = 0; k < 2; k++) begin
                        if (k == 0 || mode_split) begin
                            logic [DW+1:0] b;
                            b = pend_v[k] ? {pend_d[k], 2'b10} : {{DW{1'b0}}, 2'b11};
                            if (k == 0) expq0.push_back(b);
                            else        expq1.push_back(b);
                        end
                        pend_v[k] = 0;
                    end
                    expc0.push_back(rcnt[0]);
                    expc1.push_back(rcnt[1]);
                    rcnt[0] = 0;
                    rcnt[1] = 0;
                    await_counts = 1;
                    last_prev = 1;
                end
            end
        end
    end

    task automatic send(input logic c, input logic l, input bit gap);
        in_valid = 1'b1;
        in_data  = seq;
        in_case  = c;
        in_last  = l;
        seq      = seq + 16'h0101;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (gap) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (await_counts || expq0.size() != 0 || expq1.size() != 0 || out_valid != 2'b00);
        @(posedge clk); #1;
    endtask

    // kind: 0 alternate, 1 random, 2 all zero, 3 all one
    task automatic run_stream(input bit split, input int n, input int kind,
                              input int p0, input int p1, input bit gaps);
        mode_split = split;
        rdy_pct[0] = p0;
        rdy_pct[1] = p1;
        for (int k = 0; k < n; k++) begin
            logic c;
            case (kind)
                0: c = k[0];
                1: c = 1'($urandom_range(0, 1));
                2: c = 1'b0;
                default: c = 1'b1;
            endcase
            send(c, (k == n - 1), gaps && ($urandom_range(0, 3) == 0));
        end
        rdy_pct[0] = 100;
        rdy_pct[1] = 100;
        wait_idle();
    endtask

    initial begin
        rdy_pct[0] = 100;
        rdy_pct[1] = 100;
        for (int i = 0; i < 2; i++) begin
            pend_v[i] = 0; rcnt[i] = 0; stall_prev[i] = 0; beat_prev[i] = '0; pend_d[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 2'b00, "R1", "out_valid after reset", out_valid, 0);
        check(!counts_valid, "R1", "counts_valid after reset", counts_valid, 0);
        check(in_ready, "R1", "in_ready after reset", in_ready, 1);
        @(posedge clk); #1;

        run_stream(0, 8, 0, 100, 100, 0);   // R2 compact, alternating
        run_stream(0, 12, 1, 50, 50, 1);    // R2 R7 compact with backpressure
        run_stream(0, 10, 2, 20, 100, 0);   // R5 compact, nothing kept
        run_stream(0, 1, 3, 100, 100, 0);   // R4 single kept word
        run_stream(1, 10, 1, 100, 100, 0);  // R3 split
        run_stream(1, 20, 1, 70, 10, 1);    // R3 R7 lane1 mostly stalled
        run_stream(1, 6, 2, 40, 40, 0);     // R5 lane1 empty marker
        run_stream(1, 1, 3, 100, 100, 0);   // R5 lane0 empty, lane1 single
        run_stream(1, 16, 0, 30, 60, 1);    // R3 R4 alternating with stalls
        run_stream(0, 30, 1, 35, 35, 1);    // R2 R8 longer compact stream
        for (int s = 0; s < 6; s++)
            run_stream(1'(s % 2), 5 + s * 3, 1, 25 + s * 10, 90 - s * 10, 1); // R8

        check(expc0.size() == 0, "R8", "missing count reports", expc0.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule